// File: doc/BRIEF.md
# Per-Flow Sequence Resequencer

This block sits at one output port of a multi-path switch and puts packets back into order within each flow after they have crossed the fabric over different internal paths. Every arriving descriptor carries a flow index, which encodes the source input port and the priority class that share this output, and a sequence number stamped upstream in that flow's own sequence space. The resequencer compares the number with the value the flow expects next. A descriptor that matches can leave at once. One that is early waits in a small per-flow window until the gap before it closes.

Released descriptors from all flows merge into one departure stream with a valid/ready handshake. A round-robin arbiter takes one flow per cycle. Order is restored by exact sequence matching rather than by a timestamp offset, so traffic that is already in order passes through with only the fixed register latency. Descriptors that fall outside the window, or that land on a slot already in use, are dropped and flagged as overflow. Descriptors older than the expected number are dropped and flagged as stale. A programmable per-flow timeout skips a sequence number that never arrives, so a single lost packet cannot stall its flow indefinitely.

Top module: `flow_resequencer`

## Requirements
- R1: After reset, out_valid, err_overflow and err_stale are 0, and every flow expects sequence number 0.
- R2: A descriptor leaves only when its sequence number equals its flow's expected value. Early descriptors are held and leave in ascending sequence order once the missing ones arrive.
- R3: When the output register is free, an in-order arrival accepted at a clock edge is presented on out_valid after the next edge. No other delay is added.
- R4: Each release advances the flow's expected number by one modulo 2^SEQ_W, so it wraps from 15 to 0 with SEQ_W=4.
- R5: With offset = (in_seq - expected) mod 2^SEQ_W, a descriptor is dropped as an overflow in two cases: when WIN_DEPTH <= offset < 2^(SEQ_W-1), or when the window slot at in_seq mod WIN_DEPTH is already occupied. In either case err_overflow is high for exactly the one cycle after the acceptance edge, and the dropped descriptor never appears at the output.
- R6: A descriptor with offset >= 2^(SEQ_W-1) is stale. It is dropped, and err_stale is high for exactly the one cycle after the acceptance edge.
- R7: When several flows can release, exactly one is chosen per output load. The choice rotates round-robin, starting after the flow granted last.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_flow, out_seq and out_desc hold their values.
- R9: With skip_limit = L > 0, the flow skips the missing number after L cycles. A cycle counts when the flow's expected slot is empty, at least one later descriptor waits in its window, and no descriptor for that flow arrives in that cycle. The skipped-to descriptor then appears on the output L+1 edges after the edge that stored it. With skip_limit = 0, no number is ever skipped.
- R10: Flows keep independent expected counters and windows. Activity on one flow does not change what another flow releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An arriving descriptor is present (always accepted) |
| in_flow | input | FLOW_W | Flow index: input port and priority class |
| in_seq | input | SEQ_W | Per-flow sequence number |
| in_desc | input | DESC_W | Packet descriptor |
| skip_limit | input | TO_W | Cycles to wait on a missing number before skipping it; 0 disables skipping |
| out_valid | output | 1 | Departure descriptor valid |
| out_ready | input | 1 | Downstream accepts the departure descriptor |
| out_flow | output | FLOW_W | Flow of the departing descriptor |
| out_seq | output | SEQ_W | Sequence number of the departing descriptor |
| out_desc | output | DESC_W | Departing descriptor |
| err_overflow | output | 1 | One-cycle pulse: an arrival was dropped for window overflow |
| err_stale | output | 1 | One-cycle pulse: an arrival was dropped as stale |

## Verification
Every result has a fixed due time, counted from the edge that accepts the arrival. The error pulses appear in the cycle immediately after that edge. An in-order release appears after one further edge. A skipped-to release appears L+1 edges later. The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the acceptance edge until out_valid rises and compares that count with these numbers, rather than waiting loosely for a result. Hold and drop cases are checked by watching out_valid stay low over several cycles at the point where a wrong release would have shown.

// File: rtl/reseq_pkg.sv
package reseq_pkg;

  // Classification of an arrival against its flow's window.
  typedef enum logic [1:0] {
    CLS_STORE = 2'd0,
    CLS_OVER  = 2'd1,
    CLS_STALE = 2'd2
  } arr_cls_e;

endpackage

// File: rtl/reseq_flow_lane.sv
module reseq_flow_lane
  import reseq_pkg::*;
#(
  parameter int SEQ_W     = 4,
  parameter int WIN_DEPTH = 4,
  parameter int DESC_W    = 8,
  parameter int TO_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [DESC_W-1:0] wr_desc,
  input  logic              pop,
  input  logic [TO_W-1:0]   skip_limit,
  output logic              head_v,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [DESC_W-1:0] head_desc,
  output arr_cls_e          wr_cls
);

  localparam int IDX_W = $clog2(WIN_DEPTH);
  localparam logic [SEQ_W-1:0] WIN_S = SEQ_W'(WIN_DEPTH);

  logic [WIN_DEPTH-1:0] slot_v_q, slot_v_d;
  logic [DESC_W-1:0]    desc_q [WIN_DEPTH];
  logic [SEQ_W-1:0]     exp_q, exp_d, offset;
  logic [TO_W-1:0]      cnt_q, cnt_d;
  logic [IDX_W-1:0]     wr_idx, hd_idx;
  logic                 store, skip;

  // Classification and head view
  always_comb begin
    offset = wr_seq - exp_q;
    wr_idx = wr_seq[IDX_W-1:0];
    hd_idx = exp_q[IDX_W-1:0];
    if (offset[SEQ_W-1]) begin
      wr_cls = CLS_STALE;
    end else if ((offset >= WIN_S) || slot_v_q[wr_idx]) begin
      wr_cls = CLS_OVER;
    end else begin
      wr_cls = CLS_STORE;
    end
    store     = wr_en && (wr_cls == CLS_STORE);
    head_v    = slot_v_q[hd_idx];
    head_seq  = exp_q;
    head_desc = desc_q[hd_idx];
  end

  // Next state: window occupancy, timeout and expected counter
  always_comb begin
    slot_v_d = slot_v_q;
    if (pop)   slot_v_d[hd_idx] = 1'b0;
    if (store) slot_v_d[wr_idx] = 1'b1;

    skip  = 1'b0;
    cnt_d = cnt_q;
    if ((skip_limit == '0) || head_v || (slot_v_q == '0)) begin
      cnt_d = '0;
    end else if (!wr_en) begin
      if (cnt_q >= (skip_limit - TO_W'(1))) begin
        skip  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + TO_W'(1);
      end
    end

    exp_d = exp_q + SEQ_W'(pop) + SEQ_W'(skip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q <= '0;
      exp_q    <= '0;
      cnt_q    <= '0;
    end else begin
      slot_v_q <= slot_v_d;
      exp_q    <= exp_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      desc_q[wr_idx] <= wr_desc;
    end
  end

  // R2: only an occupied expected slot may be released
  p_pop_needs_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_v);

  // R4: a release steps the expected number by one, wrapping
  p_expect_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (exp_q == $past(exp_q) + SEQ_W'(1)));

  // R5/R6: a dropped arrival leaves the window untouched
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_cls != CLS_STORE) && !pop) |=> (slot_v_q == $past(slot_v_q)));

endmodule

// File: rtl/reseq_rr_arb.sv
module reseq_rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any_req
);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any_req   = |req;
    for (int i = 0; i < N; i++) begin
      if (req[(int'(ptr_q) + i) % N] && (grant == '0)) begin
        grant[(int'(ptr_q) + i) % N] = 1'b1;
        grant_idx = IDX_W'((int'(ptr_q) + i) % N);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance && any_req) begin
      ptr_d = (grant_idx == IDX_W'(N - 1)) ? '0 : grant_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R7: at most one flow granted, and only a requesting one
  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R7: a pending request is never left without a grant
  p_grant_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> (grant != '0));

endmodule

// File: rtl/flow_resequencer.sv
module flow_resequencer
  import reseq_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int SEQ_W     = 4,
  parameter int WIN_DEPTH = 4,
  parameter int DESC_W    = 8,
  parameter int TO_W      = 6,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [DESC_W-1:0] in_desc,
  input  logic [TO_W-1:0]   skip_limit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLOW_W-1:0] out_flow,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [DESC_W-1:0] out_desc,
  output logic              err_overflow,
  output logic              err_stale
);

  logic [NUM_FLOWS-1:0] lane_wr, lane_head_v, lane_pop, grant;
  logic [SEQ_W-1:0]     lane_seq  [NUM_FLOWS];
  logic [DESC_W-1:0]    lane_desc [NUM_FLOWS];
  arr_cls_e             lane_cls  [NUM_FLOWS];
  logic [FLOW_W-1:0]    grant_idx;
  logic                 any_req, load_en;

  logic              out_valid_q, out_valid_d;
  logic [FLOW_W-1:0] out_flow_q;
  logic [SEQ_W-1:0]  out_seq_q;
  logic [DESC_W-1:0] out_desc_q;
  logic              err_over_q, err_over_d, err_stale_q, err_stale_d;

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_lane
    assign lane_wr[g]  = in_valid && (in_flow == FLOW_W'(g));
    assign lane_pop[g] = grant[g] && load_en;

    reseq_flow_lane #(
      .SEQ_W     (SEQ_W),
      .WIN_DEPTH (WIN_DEPTH),
      .DESC_W    (DESC_W),
      .TO_W      (TO_W)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (lane_wr[g]),
      .wr_seq     (in_seq),
      .wr_desc    (in_desc),
      .pop        (lane_pop[g]),
      .skip_limit (skip_limit),
      .head_v     (lane_head_v[g]),
      .head_seq   (lane_seq[g]),
      .head_desc  (lane_desc[g]),
      .wr_cls     (lane_cls[g])
    );
  end

  reseq_rr_arb #(.N(NUM_FLOWS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (lane_head_v),
    .advance   (load_en),
    .grant     (grant),
    .grant_idx (grant_idx),
    .any_req   (any_req)
  );

  // Next state of the departure register and error pulses
  always_comb begin
    load_en     = !out_valid_q || out_ready;
    out_valid_d = load_en ? any_req : out_valid_q;
    err_over_d  = 1'b0;
    err_stale_d = 1'b0;
    for (int f = 0; f < NUM_FLOWS; f++) begin
      if (lane_wr[f] && (lane_cls[f] == CLS_OVER))  err_over_d  = 1'b1;
      if (lane_wr[f] && (lane_cls[f] == CLS_STALE)) err_stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      err_over_q  <= 1'b0;
      err_stale_q <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      err_over_q  <= err_over_d;
      err_stale_q <= err_stale_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en && any_req) begin
      out_flow_q <= grant_idx;
      out_seq_q  <= lane_seq[grant_idx];
      out_desc_q <= lane_desc[grant_idx];
    end
  end

  assign out_valid    = out_valid_q;
  assign out_flow     = out_flow_q;
  assign out_seq      = out_seq_q;
  assign out_desc     = out_desc_q;
  assign err_overflow = err_over_q;
  assign err_stale    = err_stale_q;

  // R8: a stalled departure holds its contents
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flow) &&
                                   $stable(out_seq) && $stable(out_desc)));

  // R5/R6: one arrival raises at most one kind of drop flag
  p_err_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_overflow && err_stale));

  // R7: no more than one flow releases per cycle
  p_one_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_pop) <= 1);

endmodule

// File: tb/flow_resequencer_test.sv
module flow_resequencer_test;
  localparam int NF = 4, SW = 4, WD = 4, DW = 8, TW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_flow;
  logic [SW-1:0] in_seq;
  logic [DW-1:0] in_desc;
  logic [TW-1:0] skip_limit;
  logic          out_valid, out_ready;
  logic [1:0]    out_flow;
  logic [SW-1:0] out_seq;
  logic [DW-1:0] out_desc;
  logic          err_overflow, err_stale;

  int checks = 0;
  int errors = 0;
  int nxt [NF];

  always #4 clk = ~clk;

  flow_resequencer #(.NUM_FLOWS(NF), .SEQ_W(SW), .WIN_DEPTH(WD), .DESC_W(DW), .TO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flow(in_flow), .in_seq(in_seq),
    .in_desc(in_desc), .skip_limit(skip_limit), .out_valid(out_valid), .out_ready(out_ready),
    .out_flow(out_flow), .out_seq(out_seq), .out_desc(out_desc),
    .err_overflow(err_overflow), .err_stale(err_stale));

  function automatic logic [DW-1:0] desc_of(input int f, input int s);
    return DW'(f * 37 + s * 5 + 3);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one arrival; returns at the falling edge after its acceptance edge.
  task automatic send(input int f, input int s);
    in_valid = 1'b1;
    in_flow  = 2'(f);
    in_seq   = SW'(s);
    in_desc  = desc_of(f, s);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input int f, input int s);
    int n = 0;
    while (!out_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(req, "out_valid", 32'(out_valid), 1);
    chk(req, "out_flow", 32'(out_flow), 32'(f));
    chk(req, "out_seq", 32'(out_seq), 32'(s));
    chk(req, "out_desc", 32'(out_desc), 32'(desc_of(f, s)));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_idle(input string req, input int cycles);
    repeat (cycles) @(negedge clk);
    chk(req, "out_valid idle", 32'(out_valid), 0);
  endtask

  // Falling edges from acceptance until out_valid rises.
  task automatic latency(output int n);
    n = 0;
    while (!out_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "err_overflow", 32'(err_overflow), 0);
    chk("R1", "err_stale", 32'(err_stale), 0);
  endtask

  task automatic t_in_order;
    int n;
    send(0, 0);            // R1: flow 0 expects 0 after reset
    chk("R3", "valid one edge early", 32'(out_valid), 0);
    latency(n);
    chk("R3", "in-order latency", 32'(n), 1);
    pop_expect("R1", 0, 0);
    send(0, 1); pop_expect("R3", 0, 1);
    send(0, 2); pop_expect("R3", 0, 2);
    nxt[0] = 3;
  endtask

  task automatic t_reorder;
    send(1, 2);
    send(1, 1);
    expect_idle("R2", 3);
    send(1, 0);
    pop_expect("R2", 1, 0);
    pop_expect("R2", 1, 1);
    pop_expect("R2", 1, 2);
    nxt[1] = 3;
  endtask

  task automatic t_round_robin;
    logic [1:0]    f0;
    logic [SW-1:0] s0;
    send(2, 0); send(3, 0); send(2, 1); send(3, 1);
    f0 = out_flow; s0 = out_seq;
    repeat (3) @(negedge clk);
    chk("R8", "flow held", 32'(out_flow), 32'(f0));
    chk("R8", "seq held", 32'(out_seq), 32'(s0));
    chk("R8", "valid held", 32'(out_valid), 1);
    pop_expect("R7", 2, 0);
    pop_expect("R7", 3, 0);
    pop_expect("R7", 2, 1);
    pop_expect("R7", 3, 1);
    nxt[2] = 2; nxt[3] = 2;
  endtask

  task automatic t_wrap;
    for (int p = 0; p < 8; p++) begin
      int a = nxt[3];
      int b = (nxt[3] + 1) % 16;
      send(3, b);
      send(3, a);
      pop_expect("R4", 3, a);
      pop_expect("R4", 3, b);
      nxt[3] = (nxt[3] + 2) % 16;
    end
    send(0, nxt[0]);        // R10: flow 0 unaffected by flow 3 traffic
    pop_expect("R10", 0, nxt[0]);
    nxt[0]++;
  endtask

  task automatic t_overflow;
    int e = nxt[1];
    send(1, (e + WD) % 16);
    chk("R5", "err_overflow window", 32'(err_overflow), 1);
    chk("R5", "err_stale quiet", 32'(err_stale), 0);
    @(negedge clk);
    chk("R5", "err_overflow pulse end", 32'(err_overflow), 0);
    send(1, (e + 1) % 16);
    chk("R5", "err_overflow on store", 32'(err_overflow), 0);
    send(1, (e + 1) % 16);
    chk("R5", "err_overflow occupied", 32'(err_overflow), 1);
    send(1, e);
    pop_expect("R5", 1, e);
    pop_expect("R5", 1, (e + 1) % 16);
    expect_idle("R5", 4);
    nxt[1] = (e + 2) % 16;
  endtask

  task automatic t_stale;
    int e = nxt[1];
    send(1, (e + 15) % 16);
    chk("R6", "err_stale behind", 32'(err_stale), 1);
    chk("R6", "err_overflow quiet", 32'(err_overflow), 0);
    @(negedge clk);
    chk("R6", "err_stale pulse end", 32'(err_stale), 0);
    send(1, (e + 8) % 16);
    chk("R6", "err_stale half", 32'(err_stale), 1);
    send(1, (e + 7) % 16);
    chk("R5", "err_overflow below half", 32'(err_overflow), 1);
    chk("R6", "err_stale below half", 32'(err_stale), 0);
    expect_idle("R6", 3);
    send(1, e);
    pop_expect("R6", 1, e);
    nxt[1] = (e + 1) % 16;
  endtask

  task automatic t_skip;
    int n;
    int e = nxt[2];
    skip_limit = TW'(5);
    send(2, (e + 1) % 16);
    latency(n);
    chk("R9", "skip latency", 32'(n), 6);
    pop_expect("R9", 2, (e + 1) % 16);
    e = (e + 2) % 16;
    skip_limit = '0;
    send(2, (e + 1) % 16);
    expect_idle("R9", 30);
    send(2, e);
    pop_expect("R9", 2, e);
    pop_expect("R9", 2, (e + 1) % 16);
    nxt[2] = (e + 2) % 16;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_flow = '0; in_seq = '0; in_desc = '0;
    out_ready = 1'b0; skip_limit = '0;
    for (int i = 0; i < NF; i++) nxt[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_reorder();
    t_round_robin();
    t_wrap();
    t_overflow();
    t_stale();
    t_skip();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule